// File: doc/BRIEF.md
# Host Mailbox FIFO Register Interface

This block lets a host processor exchange bytes with a system-management microcontroller through three memory-mapped 32-bit word registers. A control word holds per-condition interrupt request and enable bits. A data word pushes outgoing bytes into an 8-entry transmit queue when written, and pops incoming bytes from an 8-entry receive queue when read. A status word holds latched event flags that software clears by writing ones.

The microcontroller side has two byte streams. The transmit stream is valid/ready: the microcontroller takes a byte on any cycle where both are high. The receive stream is valid-only: a byte offered while the receive queue is full is lost, and the loss is recorded. Bytes travel in bits 15:8 of the data word in both directions.

The host bus is a single-cycle access: select, write strobe, byte address and write data. Read data is registered and appears on the clock edge after the access. The interrupt output is also registered.

Top module: `mbx_host_if`

## Requirements
- R1: After reset the status word reads 0x3, the control word reads 0, the interrupt output is low and no transmit byte is offered.
- R2: A write to the data word (offset 0x4) queues bits 15:8 of the write data. Queued bytes are offered on the transmit stream in write order, and the offered byte holds steady while ready is low.
- R3: The transmit queue holds 8 bytes. A data write while it is full is dropped.
- R4: A read of the data word pops the oldest received byte and returns it in bits 15:8, with all other bits zero.
- R5: A read of the data word while the receive queue is empty returns 0 and leaves the queue unchanged, so the next received byte is the next one read.
- R6: A received byte that arrives while the receive queue holds 8 bytes is dropped, and status bit 3 (overflow) is set. The queued bytes are kept.
- R7: Writing the status word (offset 0x8) clears each bit written as 1 and leaves bits written as 0. The overflow bit stays set until it is cleared this way. If an event and a clear land in the same cycle, the event wins.
- R8: Status bits are set by events. Bit 0 is set when the transmit queue becomes empty. Bit 1 is set when the transmit queue stops being full. Bit 2 is set on every received byte that is accepted.
- R9: The control word (offset 0x0) stores write-data bits 7:0 and reads them back, with bits 31:8 reading zero. Bits 3:0 are request bits and bits 7:4 are enable bits, in status-bit order.
- R10: One cycle after the status or control word changes, the interrupt output equals the OR over k = 0..3 of status[k] AND control[k] AND control[k+4].
- R11: Offsets 0xC through 0x1C read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq | output | 1 | Registered interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Microcontroller takes the byte |
| rx_valid | input | 1 | Received byte presented |
| rx_data | input | 8 | Received byte |

## Verification
The bench fills the transmit queue one byte past capacity, then drains it. A queue that let the extra byte overwrite the oldest entry would show up here as a wrong or extra byte. It pushes ten bytes into the receive queue and reads past empty: an off-by-one full flag would lose or repeat bytes, and a read that moves pointers on empty would return a stale byte afterwards. The interrupt output is compared against all 256 control values under three different status patterns, so a swapped request/enable pairing or a wrong bit order would miscompare. Writes to reserved offsets and partial status clears would expose a decode that aliases offsets or a clear that hits the wrong bits.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_COND = 4;
  localparam int unsigned IDX_CTL  = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned DATA_LSB = 8;

  typedef enum logic [1:0] {
    C_TX_EMPTY = 2'd0,
    C_TX_NFULL = 2'd1,
    C_RX_AVAIL = 2'd2,
    C_RX_OVF   = 2'd3
  } cond_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FULL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> $stable(cnt)); // R3 R6
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_ptr)); // R5
endmodule

// File: rtl/mbx_stat_irq.sv
module mbx_stat_irq
  import mbx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_empty,
  input  logic                tx_full,
  input  logic                rx_accept,
  input  logic                rx_drop,
  input  logic                clr_we,
  input  logic [NUM_COND-1:0] clr_bits,
  input  logic                ctl_we,
  input  logic [2*NUM_COND-1:0] ctl_wdata,
  output logic [NUM_COND-1:0] stat_q,
  output logic [2*NUM_COND-1:0] ctl_q,
  output logic                irq_o
);
  logic                prev_empty, prev_nfull;
  logic [NUM_COND-1:0] set_ev, clr_m;
  logic [NUM_COND-1:0] active;

  always_comb begin
    set_ev = '0;
    set_ev[C_TX_EMPTY] = tx_empty && !prev_empty;
    set_ev[C_TX_NFULL] = !tx_full && !prev_nfull;
    set_ev[C_RX_AVAIL] = rx_accept;
    set_ev[C_RX_OVF]   = rx_drop;
    clr_m = clr_we ? clr_bits : '0;
  end

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    assign active[k] = stat_q[k] && ctl_q[k] && ctl_q[k+NUM_COND];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_empty <= 1'b1;
      prev_nfull <= 1'b1;
      stat_q     <= NUM_COND'(4'b0011);
      ctl_q      <= '0;
      irq_o      <= 1'b0;
    end else begin
      prev_empty <= tx_empty;
      prev_nfull <= !tx_full;
      stat_q     <= (stat_q & ~clr_m) | set_ev;
      if (ctl_we) ctl_q <= ctl_wdata;
      irq_o      <= |active;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_q[C_RX_OVF] && !(clr_we && clr_bits[C_RX_OVF])) |=> stat_q[C_RX_OVF]); // R7
  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[2*NUM_COND-1:NUM_COND] == '0) |=> !irq_o); // R10
  AST_ACCEPT_SETS_AVAIL: assert property (@(posedge clk) disable iff (rst)
    rx_accept |=> stat_q[C_RX_AVAIL]); // R8
endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]         widx;
  logic                  hit_ctl, hit_data, hit_stat;
  logic                  host_wr, host_rd;
  logic                  tx_empty, tx_full, rx_empty, rx_full;
  logic [BYTE_W-1:0]     rx_head;
  logic                  rx_accept, rx_drop;
  logic [NUM_COND-1:0]   stat;
  logic [2*NUM_COND-1:0] ctl;
  logic [WORD_W-1:0]     rd_mux;
  logic                  unused_bits;

  assign widx     = reg_addr[ADDR_W-1:2];
  assign host_wr  = reg_sel && reg_wr;
  assign host_rd  = reg_sel && !reg_wr;
  assign hit_ctl  = (widx == IW'(IDX_CTL));
  assign hit_data = (widx == IW'(IDX_DATA));
  assign hit_stat = (widx == IW'(IDX_STAT));
  assign rx_accept = rx_valid && !rx_full;
  assign rx_drop   = rx_valid && rx_full;
  assign tx_valid  = !tx_empty;
  assign unused_bits = &{1'b0, reg_wdata[31:16], reg_addr[1:0]};

  mbx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr && hit_data),
    .wr_data (reg_wdata[DATA_LSB +: BYTE_W]),
    .rd_en   (tx_ready),
    .rd_data (tx_data),
    .empty   (tx_empty),
    .full    (tx_full)
  );

  mbx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rx_valid),
    .wr_data (rx_data),
    .rd_en   (host_rd && hit_data),
    .rd_data (rx_head),
    .empty   (rx_empty),
    .full    (rx_full)
  );

  mbx_stat_irq u_stat (
    .clk       (clk),
    .rst       (rst),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full),
    .rx_accept (rx_accept),
    .rx_drop   (rx_drop),
    .clr_we    (host_wr && hit_stat),
    .clr_bits  (reg_wdata[NUM_COND-1:0]),
    .ctl_we    (host_wr && hit_ctl),
    .ctl_wdata (reg_wdata[2*NUM_COND-1:0]),
    .stat_q    (stat),
    .ctl_q     (ctl),
    .irq_o     (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)  rd_mux[2*NUM_COND-1:0] = ctl;
    if (hit_stat) rd_mux[NUM_COND-1:0]   = stat;
    if (hit_data && !rx_empty) rd_mux[DATA_LSB +: BYTE_W] = rx_head;
  end

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (host_rd) reg_rdata <= rd_mux;
  end

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && widx > IW'(IDX_STAT)) |=> (reg_rdata == '0)); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R2
  AST_DATA_READ_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (host_rd && hit_data) |=> (reg_rdata[31:16] == '0 && reg_rdata[7:0] == '0)); // R4
endmodule

// File: tb/mbx_host_if_bench.sv
module mbx_host_if_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_sel, reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, tx_valid, tx_ready, rx_valid;
  logic [7:0]  tx_data, rx_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mbx_host_if u_mbx_host_if (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_wdata = '0;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic irq_sweep(input logic [3:0] s);
    logic [31:0] v;
    rd(5'h08, v);
    chk("R10 status before sweep", v, {28'h0, s});
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      cv = c[7:0];
      wr(5'h00, {24'h0, cv});
      @(negedge clk);
      chk("R10 irq", {31'h0, irq}, {31'h0, |(s & cv[3:0] & cv[7:4])});
    end
    wr(5'h00, 32'h0);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int got_n;
    rst = 1'b1; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    rd(5'h08, v); chk("R1 status", v, 32'h3);
    rd(5'h00, v); chk("R1 control", v, 32'h0);

    // R9 control readback sweep
    for (int i = 0; i < 256; i += 17) begin
      wr(5'h00, 32'hDEAD_BE00 | i);
      rd(5'h00, v);
      chk("R9 control readback", v, i);
    end
    wr(5'h00, 32'h0000_00A5);

    // R11 reserved offsets
    for (int a = 3; a < 8; a++) begin
      wr(5'(a * 4), 32'hFFFF_FFFF);
      rd(5'(a * 4), v);
      chk("R11 reserved reads zero", v, 32'h0);
    end
    rd(5'h08, v); chk("R11 status untouched", v, 32'h3);
    rd(5'h00, v); chk("R11 control untouched", v, 32'hA5);
    chk("R11 no tx byte queued", {31'h0, tx_valid}, 32'h0);
    wr(5'h00, 32'h0);

    // R7 clear all, then R2/R3 transmit fill past capacity
    wr(5'h08, 32'hF);
    rd(5'h08, v); chk("R7 clear all", v, 32'h0);
    for (int i = 0; i < 9; i++) wr(5'h04, 32'hFFFF_005A | ((32'h10 + i) << 8));
    rd(5'h08, v); chk("R8 no tx event while filling", v, 32'h0);
    chk("R2 tx_valid after writes", {31'h0, tx_valid}, 32'h1);
    chk("R2 head byte", {24'h0, tx_data}, 32'h10);
    @(negedge clk);
    chk("R2 head held while not ready", {24'h0, tx_data}, 32'h10);
    tx_ready = 1'b1;
    got_n = 0;
    for (int i = 0; i < 12; i++) begin
      if (tx_valid) begin
        chk("R2 tx order", {24'h0, tx_data}, 32'h10 + got_n);
        got_n++;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R3 exactly depth bytes sent", got_n, 8);
    rd(5'h08, v); chk("R8 tx empty and not-full events", v, 32'h3);
    irq_sweep(4'h3);

    // R6 receive overflow, R4 ordered reads, R5 empty read
    wr(5'h08, 32'hF);
    for (int i = 0; i < 10; i++) begin
      rx_valid = 1'b1; rx_data = 8'h40 + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rd(5'h08, v); chk("R6 overflow and R8 avail", v, 32'hC);
    irq_sweep(4'hC);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, v);
      chk("R4 rx byte in 15:8", v, (32'h40 + i) << 8);
    end
    rd(5'h04, v); chk("R5 empty read zero", v, 32'h0);
    rd(5'h04, v); chk("R5 second empty read zero", v, 32'h0);
    rx_valid = 1'b1; rx_data = 8'h99;
    @(negedge clk);
    rx_valid = 1'b0;
    rd(5'h04, v); chk("R5 pointers intact", v, 32'h9900);
    rd(5'h08, v); chk("R7 overflow sticky", v, 32'hC);
    wr(5'h08, 32'h4);
    rd(5'h08, v); chk("R7 partial clear", v, 32'h8);
    irq_sweep(4'h8);
    wr(5'h08, 32'h8);
    rd(5'h08, v); chk("R7 overflow cleared", v, 32'h0);

    // R7 event beats clear in same cycle
    rx_valid = 1'b1; rx_data = 8'h77;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 5'h08; reg_wdata = 32'h4;
    @(negedge clk);
    rx_valid = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
    rd(5'h08, v); chk("R7 set wins over clear", v, 32'h4);
    rd(5'h04, v); chk("R4 byte after collision", v, 32'h7700);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule